// File: doc/BRIEF.md
# Serial-in latched low-side output driver

This block accepts a serial bit stream, assembles it in an eight-bit shift stage and, on command, copies the assembled word into a storage stage whose bits drive eight sink-enable outputs. A `1` on an output asks the matching low-side driver to sink current, and a `0` turns that driver off. The shift clock and the latch clock arrive as slow external strobes. Each one passes through a synchronizer into the system clock domain, and only the rising edge of the synchronized strobe acts.

An active-low clear empties the shift stage but leaves the storage stage and the outputs as they are, so a new word can be prepared while the old one is still driving loads. An active-low enable gates all outputs to off without disturbing the stored word. A registered cascade output carries the top bit of the shift stage. Several instances can share the strobes and be chained through it into one longer register.

Top module: `serial_sink_driver`

## Requirements
- R1: After system reset, the shift stage and the storage stage are zero, the cascade output is 0 and every sink-enable output is 0.
- R2: On each synchronized rising edge of the shift strobe, the serial input enters bit 0 of the shift stage and every other bit moves up one position (bit i to bit i+1).
- R3: On each synchronized rising edge of the latch strobe, the storage stage takes all eight shift-stage bits unchanged (bit i to output i).
- R4: While the clear input is 0, the shift stage is held at zero and the clear wins over a shift edge. The storage stage and the outputs are not affected by the clear.
- R5: While the enable input is 1, all eight outputs are 0, whatever the storage stage holds.
- R6: While the enable input is 0, output i equals storage bit i with no added register delay.
- R7: The cascade output equals the top shift-stage bit as it stands after the latest shift edge. It changes only on a shift edge, so a clear does not change it.
- R8: A strobe that stays high for many system cycles produces exactly one action. A new action needs a return to 0 first.
- R9: If shift and latch edges are detected in the same system cycle, the storage stage takes the shift-stage value from before that shift.
- R10: With two instances sharing strobes and the second's serial input tied to the first's cascade output, 16 shifts load a 16-bit word. The first instance holds the last eight bits sent and the second holds the first eight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| sdata_in | input | 1 | Serial data input |
| shclk_in | input | 1 | Shift strobe, asynchronous, rising edge acts |
| latclk_in | input | 1 | Latch strobe, asynchronous, rising edge acts |
| sclr_n | input | 1 | Active-low shift-stage clear, synchronous to clk |
| oe_n | input | 1 | Active-low output enable |
| cascade_out | output | 1 | Registered top shift-stage bit for chaining |
| sink_en | output | 8 | Sink-enable outputs, 1 = driver sinks |

## Verification
All 256 words are passed through a two-instance chain. Each latched word is compared with the arithmetic value and with the word that went before, so a reversed bit order or an off-by-one shift shows up as wrong outputs on one of the instances. Clearing between loads must leave the driven word in place but empty the next latch. A clear that also wiped the storage stage, or moved the cascade bit, would drop outputs or corrupt the downstream instance. A strobe held high for twenty cycles must shift only once; a level-sensitive design would fill the register with ones. When both strobes rise together, a latch that captured the post-shift value would show the shifted word one step early. Toggling the enable must zero every output and then bring the stored word back unchanged.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
    // Default geometry of the driver
    parameter int unsigned SSD_WIDTH       = 8;
    parameter int unsigned SSD_SYNC_STAGES = 2;
endpackage

// File: rtl/ssd_edge_sync.sv
// Synchronizes one asynchronous strobe and flags its rising edge for one cycle.
module ssd_edge_sync #(
    parameter int unsigned STAGES = ssd_pkg::SSD_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_in};
        st_d.last  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.chain[STAGES-1] & ~st_q.last;
endmodule

// File: rtl/ssd_shift_stage.sv
// Serial-in parallel-out stage with a clear and a registered cascade bit.
module ssd_shift_stage #(
    parameter int unsigned WIDTH = ssd_pkg::SSD_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sh_rise,
    input  logic             sclr_n,
    input  logic             sdata_in,
    output logic [WIDTH-1:0] shift_o,
    output logic             cascade_o
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
        logic             casc;
    } shift_t;

    shift_t st_d, st_q;
    logic [WIDTH-1:0] moved;

    assign moved = {st_q.word[WIDTH-2:0], sdata_in};

    always_comb begin
        st_d = st_q;
        if (sh_rise) begin
            st_d.word = moved;
            st_d.casc = moved[WIDTH-1];
        end
        if (!sclr_n) begin
            st_d.word = '0;
            if (sh_rise) st_d.casc = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shift_o   = st_q.word;
    assign cascade_o = st_q.casc;
endmodule

// File: rtl/ssd_hold_stage.sv
// Storage stage loaded on latch edges, gated onto the sink enables.
module ssd_hold_stage #(
    parameter int unsigned WIDTH = ssd_pkg::SSD_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lat_rise,
    input  logic [WIDTH-1:0] shift_i,
    input  logic             oe_n,
    output logic [WIDTH-1:0] hold_o,
    output logic [WIDTH-1:0] sink_o
);
    logic [WIDTH-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (lat_rise) hold_d = shift_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_gate
            assign sink_o[gi] = hold_q[gi] & ~oe_n;
        end
    endgenerate

    assign hold_o = hold_q;
endmodule

// File: rtl/serial_sink_driver.sv
module serial_sink_driver #(
    parameter int unsigned WIDTH       = ssd_pkg::SSD_WIDTH,
    parameter int unsigned SYNC_STAGES = ssd_pkg::SSD_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sdata_in,
    input  logic             shclk_in,
    input  logic             latclk_in,
    input  logic             sclr_n,
    input  logic             oe_n,
    output logic             cascade_out,
    output logic [WIDTH-1:0] sink_en
);
    logic             sh_rise;
    logic             lat_rise;
    logic [WIDTH-1:0] shift_q;
    logic [WIDTH-1:0] hold_q;

    ssd_edge_sync #(.STAGES(SYNC_STAGES)) u_sh_sync (
        .clk(clk), .rst_n(rst_n), .async_in(shclk_in), .rise_o(sh_rise)
    );

    ssd_edge_sync #(.STAGES(SYNC_STAGES)) u_lat_sync (
        .clk(clk), .rst_n(rst_n), .async_in(latclk_in), .rise_o(lat_rise)
    );

    ssd_shift_stage #(.WIDTH(WIDTH)) u_shift (
        .clk(clk), .rst_n(rst_n), .sh_rise(sh_rise), .sclr_n(sclr_n),
        .sdata_in(sdata_in), .shift_o(shift_q), .cascade_o(cascade_out)
    );

    ssd_hold_stage #(.WIDTH(WIDTH)) u_hold (
        .clk(clk), .rst_n(rst_n), .lat_rise(lat_rise), .shift_i(shift_q),
        .oe_n(oe_n), .hold_o(hold_q), .sink_o(sink_en)
    );
endmodule

// File: rtl/ssd_checker.sv
module ssd_checker #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sdata_in,
    input logic             sclr_n,
    input logic             sh_rise,
    input logic             lat_rise,
    input logic [WIDTH-1:0] shift_q,
    input logic [WIDTH-1:0] hold_q,
    input logic             cascade_out
);
    assert_shift_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_rise && sclr_n) |=> shift_q[0] == $past(sdata_in));

    assert_shift_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_rise && sclr_n) |=> shift_q[WIDTH-1:1] == $past(shift_q[WIDTH-2:0]));

    assert_latch_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lat_rise |=> hold_q == $past(shift_q));

    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_rise |=> $stable(hold_q));

    assert_clear_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sclr_n |=> shift_q == '0);

    assert_cascade_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_rise |=> $stable(cascade_out));

    assert_cascade_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sh_rise |=> cascade_out == shift_q[WIDTH-1]);

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sh_rise |=> !sh_rise);
endmodule

bind serial_sink_driver ssd_checker #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .sdata_in(sdata_in), .sclr_n(sclr_n),
    .sh_rise(sh_rise), .lat_rise(lat_rise), .shift_q(shift_q),
    .hold_q(hold_q), .cascade_out(cascade_out)
);

// File: tb/tb_serial_sink_driver.sv
module tb_serial_sink_driver;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sdata = 1'b0;
    logic shclk = 1'b0;
    logic latclk = 1'b0;
    logic sclr_n = 1'b1;
    logic oe_n = 1'b0;
    logic casc_a, casc_b;
    logic [7:0] out_a, out_b;
    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    serial_sink_driver dut (
        .clk(clk), .rst_n(rst_n), .sdata_in(sdata), .shclk_in(shclk),
        .latclk_in(latclk), .sclr_n(sclr_n), .oe_n(oe_n),
        .cascade_out(casc_a), .sink_en(out_a)
    );

    serial_sink_driver dut_nx (
        .clk(clk), .rst_n(rst_n), .sdata_in(casc_a), .shclk_in(shclk),
        .latclk_in(latclk), .sclr_n(sclr_n), .oe_n(oe_n),
        .cascade_out(casc_b), .sink_en(out_b)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b, input int hi_len);
        @(negedge clk) sdata = b; shclk = 1'b1;
        repeat (hi_len) @(negedge clk);
        shclk = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic latch_word();
        @(negedge clk) latclk = 1'b1;
        repeat (5) @(negedge clk);
        latclk = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        logic [7:0] prev;
        logic [15:0] word;
        repeat (3) @(negedge clk);
        check("R1 out_a", out_a, 8'h00);
        check("R1 casc_a", {7'd0, casc_a}, 8'h00);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 out_b", out_b, 8'h00);

        // R2 R3 R10: every word through the chain, top bit first
        prev = 8'h00;
        for (int v = 0; v < 256; v++) begin
            for (int i = 7; i >= 0; i--) shift_bit(v[i], 4);
            latch_word();
            check("R2 R3 word", out_a, v[7:0]);
            check("R10 downstream", out_b, prev);
            check("R7 cascade", {7'd0, casc_a}, {7'd0, v[7]});
            prev = v[7:0];
        end

        // R4: clear leaves outputs and cascade alone, empties next latch
        @(negedge clk) sclr_n = 1'b0;
        repeat (6) @(negedge clk);
        sclr_n = 1'b1;
        @(negedge clk);
        check("R4 hold kept a", out_a, 8'hFF);
        check("R4 hold kept b", out_b, 8'hFE);
        check("R7 cascade after clear", {7'd0, casc_a}, 8'h01);
        latch_word();
        check("R4 cleared latch a", out_a, 8'h00);
        check("R4 cleared latch b", out_b, 8'h00);

        // R8: long high strobe shifts once; cascade 1 feeds downstream
        shift_bit(1'b1, 20);
        latch_word();
        check("R8 single shift a", out_a, 8'h01);
        check("R8 R7 single shift b", out_b, 8'h01);

        // R10: explicit 16-bit load
        word = 16'hC35A;
        for (int i = 15; i >= 0; i--) shift_bit(word[i], 4);
        latch_word();
        check("R10 chain low byte", out_a, 8'h5A);
        check("R10 chain high byte", out_b, 8'hC3);

        // R9: simultaneous edges latch the pre-shift value
        @(negedge clk) sdata = 1'b1; shclk = 1'b1; latclk = 1'b1;
        repeat (5) @(negedge clk);
        shclk = 1'b0; latclk = 1'b0;
        repeat (5) @(negedge clk);
        check("R9 pre-shift a", out_a, 8'h5A);
        check("R9 pre-shift b", out_b, 8'hC3);
        latch_word();
        check("R9 post-shift a", out_a, 8'hB5);
        check("R9 post-shift b", out_b, 8'h86);

        // R5 R6: enable gating
        @(negedge clk) oe_n = 1'b1;
        #1;
        check("R5 off a", out_a, 8'h00);
        check("R5 off b", out_b, 8'h00);
        @(negedge clk) oe_n = 1'b0;
        #1;
        check("R6 back a", out_a, 8'hB5);
        check("R6 back b", out_b, 8'h86);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule